// File: doc/BRIEF.md
# Indirect Vector-Table Fetch Sequencer

This block takes the processor from the running program into an interrupt or trap handler by reading the handler location from a table in memory. A request carries an 8-bit type number. A hardware interrupt and a software trap instruction supply the same kind of request and go through the same vectoring path. The sequencer first saves the current code segment and instruction pointer on a downward-growing stack. It then reads the 4-byte table entry at type×4 and produces the new instruction pointer, code segment and stack pointer. All memory traffic goes through one byte-wide port, one byte per cycle.

A return request performs the reverse operation. It pops the saved instruction pointer and code segment from the stack and releases the four stack bytes. The processor core samples the three result words when the done pulse appears. It presents its current register values on the request cycle.

Top module: `vf_vector_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done`, `mem_rd` and `mem_wr` are low, and `new_ip`, `new_cs` and `new_sp` are zero.
- R2: An accepted entry request writes the code segment and then the instruction pointer, as four byte writes. The stack pointer is decremented by 2 before each 16-bit word is written. Each word is stored little-endian, so `cur_cs` lands at `cur_sp`-2/-1 and `cur_ip` at `cur_sp`-4/-3, low byte at the lower address. `new_sp` becomes `cur_sp`-4.
- R3: The table entry for type n is read at addresses 4n to 4n+3, all below 0x400. Bytes 4n (low) and 4n+1 (high) become `new_ip`. Bytes 4n+2 (low) and 4n+3 (high) become `new_cs`.
- R4: A hardware interrupt request (`irq_valid`, `irq_type`) and a software trap request (`trap_valid`, `trap_type`) with the same type give identical results and identical memory traffic.
- R5: A return request reads `new_ip` from `cur_sp` (low) and `cur_sp`+1, then `new_cs` from `cur_sp`+2 and `cur_sp`+3. It sets `new_sp` to `cur_sp`+4 and performs no memory writes.
- R6: `busy` rises the cycle after a request is accepted. It stays high for 9 cycles on entry and 5 cycles on return. `done` is high for exactly one cycle, the last busy cycle, and the results are valid from that cycle on.
- R7: Requests arriving while `busy` is high are ignored. The results and the stack contents are those of the sequence already running, and no new sequence follows it.
- R8: When several requests arrive together while idle, the interrupt wins over the trap, and the trap wins over the return.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle, and neither is high while `busy` is low. Read data on `mem_rdata` is taken in the same cycle as `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_valid | input | 1 | Hardware interrupt request |
| irq_type | input | 8 | Type number of the interrupt |
| trap_valid | input | 1 | Software trap request |
| trap_type | input | 8 | Type number carried by the trap instruction |
| ret_valid | input | 1 | Return-from-handler request |
| cur_ip | input | 16 | Current instruction pointer |
| cur_cs | input | 16 | Current code segment |
| cur_sp | input | 16 | Current stack pointer |
| mem_addr | output | 16 | Byte address to memory |
| mem_rd | output | 1 | Byte read strobe |
| mem_wr | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the cycle of `mem_rd` |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| new_ip | output | 16 | Resulting instruction pointer |
| new_cs | output | 16 | Resulting code segment |
| new_sp | output | 16 | Resulting stack pointer |

## Verification
Random entry-and-return pairs use random types, pointer values and odd or even stack pointers against a table whose bytes all differ. A swapped byte order, a wrong word order or a wrong table offset therefore shows up as a wrong value. Directed cases cover type 0 and type 255, the extreme ends of the table. They also compare an interrupt with a trap of the same type, and apply simultaneous requests to tell the priority apart. A burst of requests during a running sequence shows whether anything leaks into the results, the stack or the busy length.

// File: rtl/vf_pkg.sv
// Shared definitions for the vector-fetch sequencer.
// Assumes byte-wide memory and 16-bit pointer words.
package vf_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int ENTRY_BYTES = 4;
    typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_LOAD, ST_FIN} vf_state_e;
endpackage

// File: rtl/vf_ctrl.sv
// Sequencer control: arbitrates requests, latches the operands and steps
// through the push and load phases one byte per cycle.
// Assumes requests are only sampled while idle.
module vf_ctrl
    import vf_pkg::*;
#(
    parameter int TYPE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_valid,
    input  logic [TYPE_W-1:0] irq_type,
    input  logic              trap_valid,
    input  logic [TYPE_W-1:0] trap_type,
    input  logic              ret_valid,
    input  logic [WORD_W-1:0] cur_ip,
    input  logic [WORD_W-1:0] cur_cs,
    input  logic [ADDR_W-1:0] cur_sp,
    output vf_state_e         state,
    output logic [1:0]        step,
    output logic              is_ret,
    output logic [WORD_W-1:0] ip_q,
    output logic [WORD_W-1:0] cs_q,
    output logic [ADDR_W-1:0] sp_q,
    output logic [TYPE_W-1:0] type_q,
    output logic              busy,
    output logic              done,
    output logic              mem_rd,
    output logic              mem_wr
);
    logic any_req;
    logic last_step;

    // Request detection and end-of-phase detection.
    always_comb begin
        any_req   = irq_valid | trap_valid | ret_valid;
        last_step = (step == 2'd3);
    end

    // State, step counter and operand latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            step   <= 2'd0;
            is_ret <= 1'b0;
            ip_q   <= '0;
            cs_q   <= '0;
            sp_q   <= '0;
            type_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (any_req) begin
                    ip_q   <= cur_ip;
                    cs_q   <= cur_cs;
                    sp_q   <= cur_sp;
                    type_q <= irq_valid ? irq_type : trap_type;
                    is_ret <= !(irq_valid || trap_valid);
                    step   <= 2'd0;
                    state  <= (irq_valid || trap_valid) ? ST_PUSH : ST_LOAD;
                end
                ST_PUSH: begin
                    step <= step + 2'd1;
                    if (last_step) state <= ST_LOAD;
                end
                ST_LOAD: begin
                    step <= step + 2'd1;
                    if (last_step) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decoded outputs.
    always_comb begin
        busy   = (state != ST_IDLE);
        done   = (state == ST_FIN);
        mem_wr = (state == ST_PUSH);
        mem_rd = (state == ST_LOAD);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && any_req) |=> busy); // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R6
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R9
    AST_NO_WRITE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_ret) |-> !mem_wr); // R5
endmodule

// File: rtl/vf_addr_gen.sv
// Address and write-data generation for the byte-wide memory port.
// Push: CS at sp-2/sp-1, IP at sp-4/sp-3. Load: table 4n+step or sp+step.
// Assumes ADDR_W is at least TYPE_W+2.
module vf_addr_gen
    import vf_pkg::*;
#(
    parameter int TYPE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vf_state_e         state,
    input  logic [1:0]        step,
    input  logic              is_ret,
    input  logic [WORD_W-1:0] ip_q,
    input  logic [WORD_W-1:0] cs_q,
    input  logic [ADDR_W-1:0] sp_q,
    input  logic [TYPE_W-1:0] type_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata
);
    localparam logic [ADDR_W-1:0] TABLE_LIMIT = ADDR_W'(ENTRY_BYTES << TYPE_W);

    logic [ADDR_W-1:0] tbl_base;
    logic [ADDR_W-1:0] push_off;

    // Entry base address is type times four.
    always_comb tbl_base = ADDR_W'({type_q, 2'b00});

    // Stack offset of each pushed byte, below the saved stack pointer.
    always_comb begin
        case (step)
            2'd0:    push_off = ADDR_W'(2);
            2'd1:    push_off = ADDR_W'(1);
            2'd2:    push_off = ADDR_W'(4);
            default: push_off = ADDR_W'(3);
        endcase
    end

    // Address multiplexer.
    always_comb begin
        if (state == ST_PUSH)  mem_addr = sp_q - push_off;
        else if (is_ret)       mem_addr = sp_q + ADDR_W'(step);
        else                   mem_addr = tbl_base + ADDR_W'(step);
    end

    // Byte select for the push phase: CS low, CS high, IP low, IP high.
    always_comb begin
        case (step)
            2'd0:    mem_wdata = cs_q[7:0];
            2'd1:    mem_wdata = cs_q[15:8];
            2'd2:    mem_wdata = ip_q[7:0];
            default: mem_wdata = ip_q[15:8];
        endcase
    end

    AST_TABLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !is_ret) |-> (mem_addr < TABLE_LIMIT)); // R3
endmodule

// File: rtl/vf_word_asm.sv
// Collects the four loaded bytes into IP and CS and commits them with
// the updated stack pointer after the last byte.
// Assumes bytes arrive in order: IP low, IP high, CS low, CS high.
module vf_word_asm
    import vf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_rd,
    input  logic [1:0]        step,
    input  logic              is_ret,
    input  logic [ADDR_W-1:0] sp_q,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_cs,
    output logic [ADDR_W-1:0] new_sp
);
    logic [WORD_W-1:0] stage_ip;
    logic [BYTE_W-1:0] stage_cs_lo;

    // Byte staging and final commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_ip    <= '0;
            stage_cs_lo <= '0;
            new_ip      <= '0;
            new_cs      <= '0;
            new_sp      <= '0;
        end else if (mem_rd) begin
            case (step)
                2'd0: stage_ip[7:0]  <= mem_rdata;
                2'd1: stage_ip[15:8] <= mem_rdata;
                2'd2: stage_cs_lo    <= mem_rdata;
                default: begin
                    new_ip <= stage_ip;
                    new_cs <= {mem_rdata, stage_cs_lo};
                    new_sp <= is_ret ? sp_q + ADDR_W'(ENTRY_BYTES)
                                     : sp_q - ADDR_W'(ENTRY_BYTES);
                end
            endcase
        end
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_rd) |-> ($stable(new_ip) && $stable(new_cs) && $stable(new_sp))); // R7
endmodule

// File: rtl/vf_vector_seq.sv
// Top of the vector-fetch sequencer: saves CS and IP on the stack, reads
// the 4-byte table entry at type*4, or pops a saved pair on return.
// Assumes a byte memory whose read data is valid in the strobe cycle.
module vf_vector_seq
    import vf_pkg::*;
#(
    parameter int TYPE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_valid,
    input  logic [TYPE_W-1:0] irq_type,
    input  logic              trap_valid,
    input  logic [TYPE_W-1:0] trap_type,
    input  logic              ret_valid,
    input  logic [WORD_W-1:0] cur_ip,
    input  logic [WORD_W-1:0] cur_cs,
    input  logic [ADDR_W-1:0] cur_sp,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_cs,
    output logic [ADDR_W-1:0] new_sp
);
    vf_state_e         state;
    logic [1:0]        step;
    logic              is_ret;
    logic [WORD_W-1:0] ip_q;
    logic [WORD_W-1:0] cs_q;
    logic [ADDR_W-1:0] sp_q;
    logic [TYPE_W-1:0] type_q;

    vf_ctrl #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .irq_valid(irq_valid), .irq_type(irq_type),
        .trap_valid(trap_valid), .trap_type(trap_type),
        .ret_valid(ret_valid),
        .cur_ip(cur_ip), .cur_cs(cur_cs), .cur_sp(cur_sp),
        .state(state), .step(step), .is_ret(is_ret),
        .ip_q(ip_q), .cs_q(cs_q), .sp_q(sp_q), .type_q(type_q),
        .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    vf_addr_gen #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) i_addr (
        .clk(clk), .rst_n(rst_n),
        .state(state), .step(step), .is_ret(is_ret),
        .ip_q(ip_q), .cs_q(cs_q), .sp_q(sp_q), .type_q(type_q),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    vf_word_asm #(.ADDR_W(ADDR_W)) i_asm (
        .clk(clk), .rst_n(rst_n),
        .mem_rd(mem_rd), .step(step), .is_ret(is_ret), .sp_q(sp_q),
        .mem_rdata(mem_rdata),
        .new_ip(new_ip), .new_cs(new_cs), .new_sp(new_sp)
    );

    AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy); // R9
endmodule

// File: tb/test_vf_vector_seq.sv
// Self-checking bench: behavioural byte memory, random entry/return pairs
// and directed corner cases.
module test_vf_vector_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_valid = 1'b0, trap_valid = 1'b0, ret_valid = 1'b0;
    logic [7:0]  irq_type = '0, trap_type = '0;
    logic [15:0] cur_ip = '0, cur_cs = '0, cur_sp = '0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done;
    logic [15:0] new_ip, new_cs, new_sp;

    logic [7:0]  mem [MEM_BYTES];
    int          checks = 0, fails = 0, cycles = 0;
    int          wr_cnt = 0, rd_cnt = 0, rw_both = 0;

    vf_vector_seq i_vf_vector_seq (
        .clk(clk), .rst_n(rst_n),
        .irq_valid(irq_valid), .irq_type(irq_type),
        .trap_valid(trap_valid), .trap_type(trap_type),
        .ret_valid(ret_valid),
        .cur_ip(cur_ip), .cur_cs(cur_cs), .cur_sp(cur_sp),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done),
        .new_ip(new_ip), .new_cs(new_cs), .new_sp(new_sp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:0]];

    // Behavioural memory write and port activity counters.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_wr) wr_cnt <= wr_cnt + 1;
        if (mem_rd) rd_cnt <= rd_cnt + 1;
        if (mem_rd && mem_wr) rw_both <= rw_both + 1;
        if (!busy && (mem_rd || mem_wr)) rw_both <= rw_both + 1;
    end

    function automatic logic [7:0] tbl_byte(input int a);
        return 8'((a * 29) ^ 8'h5A ^ (a >> 3));
    endfunction

    function automatic logic [15:0] exp_ip(input logic [7:0] t);
        return {tbl_byte(int'(t) * 4 + 1), tbl_byte(int'(t) * 4)};
    endfunction

    function automatic logic [15:0] exp_cs(input logic [7:0] t);
        return {tbl_byte(int'(t) * 4 + 3), tbl_byte(int'(t) * 4 + 2)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one request; kind 0=irq 1=trap 2=return 3=irq+trap 4=trap+return.
    // inject=1 fires extra requests while busy.
    task automatic run_seq(input int kind, input logic [7:0] t, input logic [7:0] t2,
                           input logic [15:0] ip, input logic [15:0] cs, input logic [15:0] sp,
                           input bit inject, output int bc, output int dc);
        int w0;
        @(negedge clk);
        w0 = wr_cnt;
        cur_ip = ip; cur_cs = cs; cur_sp = sp;
        irq_valid  = (kind == 0 || kind == 3);
        trap_valid = (kind == 1 || kind == 3 || kind == 4);
        ret_valid  = (kind == 2 || kind == 4);
        irq_type   = t;
        trap_type  = (kind == 3) ? t2 : t;
        @(negedge clk);
        irq_valid = 0; trap_valid = 0; ret_valid = 0;
        bc = 0; dc = 0;
        while (busy && bc < 40) begin
            if (done) dc++;
            bc++;
            if (inject && bc == 2) begin
                irq_valid = 1; irq_type = t2; trap_valid = 1; trap_type = t2;
                ret_valid = 1; cur_sp = sp ^ 16'h0010; cur_ip = ~ip; cur_cs = ~cs;
            end
            if (inject && bc == 4) begin
                irq_valid = 0; trap_valid = 0; ret_valid = 0;
            end
            @(negedge clk);
        end
        wr_cnt = wr_cnt; // keep
        bc = bc; dc = dc;
        w0 = wr_cnt - w0;
        last_wr = w0;
    endtask

    int last_wr;

    task automatic check_entry(input string req, input logic [7:0] t, input logic [15:0] ip,
                               input logic [15:0] cs, input logic [15:0] sp, input int bc, input int dc);
        logic [15:0] s;
        s = sp;
        chk({req, " R3 new_ip"}, 32'(new_ip), 32'(exp_ip(t)));
        chk({req, " R3 new_cs"}, 32'(new_cs), 32'(exp_cs(t)));
        chk({req, " R2 new_sp"}, 32'(new_sp), 32'(16'(s - 16'd4)));
        chk({req, " R2 stack"},
            {mem[12'(s - 16'd1)], mem[12'(s - 16'd2)], mem[12'(s - 16'd3)], mem[12'(s - 16'd4)]},
            {cs[15:8], cs[7:0], ip[15:8], ip[7:0]});
        chk({req, " R2 writes"}, 32'(last_wr), 32'd4);
        chk({req, " R6 busy len"}, 32'(bc), 32'd9);
        chk({req, " R6 done count"}, 32'(dc), 32'd1);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        int bc, dc, r;
        logic [7:0] t;
        logic [15:0] ip, cs, sp, ip2, cs2;
        for (int a = 0; a < MEM_BYTES; a++) mem[a] = tbl_byte(a);
        r = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1: reset state, held and first cycle after release.
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 strobes", {mem_rd, mem_wr}, 0);
        chk("R1 results", {new_ip, new_cs}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {busy, done, mem_rd, mem_wr}, 0);
        chk("R1 sp", 32'(new_sp), 0);

        // Directed: type 0 and type 255 via interrupt, with return.
        run_seq(0, 8'd0, 8'd0, 16'h1234, 16'hABCD, 16'h0900, 0, bc, dc);
        check_entry("irq t0", 8'd0, 16'h1234, 16'hABCD, 16'h0900, bc, dc);
        run_seq(0, 8'd255, 8'd0, 16'hFEDC, 16'h0102, 16'h0A01, 0, bc, dc);
        check_entry("irq t255", 8'd255, 16'hFEDC, 16'h0102, 16'h0A01, bc, dc);
        run_seq(2, 8'd0, 8'd0, 16'h5555, 16'h6666, new_sp, 0, bc, dc);
        chk("R5 ret ip", 32'(new_ip), 32'h0000FEDC);
        chk("R5 ret cs", 32'(new_cs), 32'h00000102);
        chk("R5 ret sp", 32'(new_sp), 32'h00000A01);
        chk("R5 ret writes", 32'(last_wr), 0);
        chk("R6 ret busy len", 32'(bc), 5);
        chk("R6 ret done count", 32'(dc), 1);

        // R4: trap with same type matches interrupt.
        run_seq(1, 8'd255, 8'd0, 16'hFEDC, 16'h0102, 16'h0A01, 0, bc, dc);
        check_entry("trap t255 R4", 8'd255, 16'hFEDC, 16'h0102, 16'h0A01, bc, dc);

        // R8: irq beats trap; trap beats return.
        run_seq(3, 8'd17, 8'd99, 16'h1111, 16'h2222, 16'h0C00, 0, bc, dc);
        check_entry("R8 irq over trap", 8'd17, 16'h1111, 16'h2222, 16'h0C00, bc, dc);
        run_seq(4, 8'd42, 8'd0, 16'h3333, 16'h4444, 16'h0C80, 0, bc, dc);
        check_entry("R8 trap over ret", 8'd42, 16'h3333, 16'h4444, 16'h0C80, bc, dc);

        // R7: requests during busy are ignored.
        run_seq(0, 8'd7, 8'd200, 16'h7777, 16'h8888, 16'h0D00, 1, bc, dc);
        check_entry("R7 inject", 8'd7, 16'h7777, 16'h8888, 16'h0D00, bc, dc);
        chk("R7 no follow-up", 32'(busy), 0);
        @(negedge clk);
        chk("R7 still idle", 32'(busy), 0);
        chk("R7 stack untouched above", 32'(mem[12'(16'h0D00 - 16'h0014)]),
            32'(tbl_byte(16'h0D00 - 16'h0014)));

        // Random entry/return pairs.
        for (int i = 0; i < 30; i++) begin
            t  = 8'($urandom);
            ip = 16'($urandom); cs = 16'($urandom);
            sp = 16'h0800 + 16'($urandom_range(0, 16'h07F0));
            ip2 = 16'($urandom); cs2 = 16'($urandom);
            run_seq(i % 2, t, 8'd0, ip, cs, sp, 0, bc, dc);
            check_entry("rand entry", t, ip, cs, sp, bc, dc);
            run_seq(2, 8'd0, 8'd0, ip2, cs2, new_sp, 0, bc, dc);
            chk("R5 rand ret ip", 32'(new_ip), 32'(ip));
            chk("R5 rand ret cs", 32'(new_cs), 32'(cs));
            chk("R5 rand ret sp", 32'(new_sp), 32'(sp));
            chk("R6 rand ret len", 32'(bc), 5);
        end
        chk("R9 strobe conflicts", 32'(rw_both), 0);
        chk("R9 read count", 32'(rd_cnt), 32'(4 * 7 + 4 * 60));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule